// File: doc/BRIEF.md
# Selectable Capture Trigger Generator

This block watches a set of receive, transmit and gain-control status signals and raises a one-clock trigger pulse for a sample capture buffer whenever the event picked by a 5-bit mode input occurs. The events cover frame check results, header check results, preamble detection, the first nonzero transmit sample, threshold crossings of RSSI and gain, gain-lock transitions, transmit start/done strobes, and edges of the baseband-ongoing and RF-ongoing levels. Transmit events can also be qualified by an ACK-required flag or by the other antenna's sample amplitude being above a programmable threshold.

Every edge, transition and crossing is found by comparing the present input with a registered copy taken one clock earlier. The trigger output is registered, so the pulse appears one clock after the qualifying inputs are presented. A small state machine has two states: `ST_PRIME` (the first clock after reset, when the registered copies do not yet hold real history, so no trigger can fire) and `ST_RUN` (normal operation). Transition `PRIME_TO_RUN` is taken unconditionally on the first clock after reset; `ST_RUN` holds until reset. A free-run input combined with mode 0 makes the trigger fire on every clock.

Strobe inputs (frame check done, header check done, preamble flags, transmit start/done) are expected to be one-clock pulses; the block passes them through qualified by the mode.

Top module: `capture_trigger_gen`

## Requirements
- R1: While reset is asserted `trig_o` is 0, and in the first clock after reset is released (`ST_PRIME`) no trigger is produced whatever the inputs.
- R2: `trig_o` is registered: it is 1 in the clock after the clock in which the qualifying inputs were presented, and returns to 0 when the condition no longer holds.
- R3: Mode 0 fires on any frame check done strobe, mode 1 only when the pass flag is 1, mode 2 only when it is 0.
- R4: Mode 4 fires on header check done with pass, mode 5 with fail; mode 6 on any header check done with the HT flag 1, mode 7 with the HT flag 0.
- R5: Modes 8 and 9 fire on the long- and short-preamble flags; mode 3 fires when the 32-bit transmit I/Q word goes from all-zero to nonzero.
- R6: Mode 10 fires once when RSSI goes from not-above to strictly above its threshold; mode 11 fires once when RSSI goes from not-below to strictly below it; equality counts as neither.
- R7: Modes 14 and 15 behave as R6 for the 7-bit gain value against the gain threshold.
- R8: Mode 12 fires when the gain-lock flag goes 1 to 0, mode 13 when it goes 0 to 1.
- R9: Modes 16 to 21 fire on transmit start, transmit done, baseband-ongoing rise, baseband-ongoing fall, RF-ongoing rise, RF-ongoing fall.
- R10: Modes 22 to 27 are the same six events in the same order, firing only when the ACK-required flag is 1.
- R11: Mode 28 fires once when (baseband-ongoing and amplitude strictly above the amplitude threshold) becomes true; mode 29 likewise with RF-ongoing.
- R12: Mode 30 fires on transmit start while the amplitude is above threshold; mode 31 additionally requires ACK-required.
- R13: With free-run 1 and mode 0 the trigger is 1 on every clock of `ST_RUN`; with any other mode free-run has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_i | input | 5 | Event selector, 0 to 31 |
| free_run_i | input | 1 | Continuous trigger when mode is 0 |
| fcs_done_i | input | 1 | Frame check result strobe |
| fcs_ok_i | input | 1 | Frame check passed |
| sig_done_i | input | 1 | Header check result strobe |
| sig_ok_i | input | 1 | Header check passed |
| sig_ht_i | input | 1 | Frame is HT |
| long_pre_i | input | 1 | Long preamble detected strobe |
| short_pre_i | input | 1 | Short preamble detected strobe |
| tx_iq_i | input | 2*IQ_W | Transmit I/Q word (I high, Q low) |
| rssi_i | input | RSSI_W | RSSI, half-dB units |
| rssi_th_i | input | RSSI_W | RSSI threshold |
| gain_lock_i | input | 1 | Gain control locked |
| gain_i | input | GAIN_W | Gain value |
| gain_th_i | input | GAIN_W | Gain threshold |
| tx_start_i | input | 1 | Transmit start strobe |
| tx_done_i | input | 1 | Transmit done strobe |
| bb_on_i | input | 1 | Baseband transmit ongoing level |
| rf_on_i | input | 1 | RF transmit ongoing level |
| ack_req_i | input | 1 | Current transmit frame expects ACK |
| amp_i | input | AMP_W | Other-antenna sample amplitude |
| amp_th_i | input | AMP_W | Amplitude threshold |
| trig_o | output | 1 | One-clock capture trigger |

## Verification
Every result of this block is due exactly one clock after the inputs that cause it: strobes, crossings and edges all land in `trig_o` at the next rising edge, and an edge is judged against the value presented one clock before. The bench drives each stimulus on the falling edge, queues the expected trigger for it, and compares just after the following rising edge, so every check lands on the single clock in which that stimulus's result is visible. Held levels are checked on the following clock to show the pulse does not repeat, and the first clock after reset is checked to show priming suppresses spurious edges.

// File: rtl/trig_pkg.sv
package trig_pkg;
    localparam int MODE_W = 5;
    localparam int NUM_MODES = 1 << MODE_W;

    // bit positions inside the history vector
    localparam int H_IQNZ = 0;
    localparam int H_LOCK = 1;
    localparam int H_BB   = 2;
    localparam int H_RF   = 3;
    localparam int H_BBA  = 4;
    localparam int H_RFA  = 5;
    localparam int HIST_N = 6;

    typedef enum logic [0:0] {
        ST_PRIME = 1'b0,
        ST_RUN   = 1'b1
    } trig_state_e;

    typedef enum logic [MODE_W-1:0] {
        M_FCS_ANY = 5'd0,  M_FCS_OK = 5'd1,   M_FCS_BAD = 5'd2,  M_TXIQ_NZ = 5'd3,
        M_SIG_OK = 5'd4,   M_SIG_BAD = 5'd5,  M_SIG_HT = 5'd6,   M_SIG_LEG = 5'd7,
        M_LONG_PRE = 5'd8, M_SHORT_PRE = 5'd9, M_RSSI_UP = 5'd10, M_RSSI_DN = 5'd11,
        M_UNLOCK = 5'd12,  M_LOCK = 5'd13,    M_GAIN_UP = 5'd14, M_GAIN_DN = 5'd15,
        M_TX_START = 5'd16, M_TX_DONE = 5'd17, M_BB_RISE = 5'd18, M_BB_FALL = 5'd19,
        M_RF_RISE = 5'd20, M_RF_FALL = 5'd21, M_A_TX_START = 5'd22, M_A_TX_DONE = 5'd23,
        M_A_BB_RISE = 5'd24, M_A_BB_FALL = 5'd25, M_A_RF_RISE = 5'd26, M_A_RF_FALL = 5'd27,
        M_BB_AMP = 5'd28,  M_RF_AMP = 5'd29,  M_START_AMP = 5'd30, M_A_START_AMP = 5'd31
    } trig_mode_e;
endpackage

// File: rtl/sig_history.sv
module sig_history #(
    parameter int N = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] d,
    output logic [N-1:0] q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end
endmodule

// File: rtl/level_cross.sv
module level_cross #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] val,
    input  logic [W-1:0] th,
    output logic         go_up,
    output logic         go_dn
);
    logic above, below, above_q, below_q;

    assign above = val > th;
    assign below = val < th;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            above_q <= 1'b0;
            below_q <= 1'b0;
        end else begin
            above_q <= above;
            below_q <= below;
        end
    end

    // fire only on the sample where the comparison turns true
    assign go_up = above & ~above_q;
    assign go_dn = below & ~below_q;
endmodule

// File: rtl/event_mux.sv
module event_mux
    import trig_pkg::*;
(
    input  logic [MODE_W-1:0] mode,
    input  logic [HIST_N-1:0] cur,
    input  logic [HIST_N-1:0] prev,
    input  logic              fcs_done,
    input  logic              fcs_ok,
    input  logic              sig_done,
    input  logic              sig_ok,
    input  logic              sig_ht,
    input  logic              long_pre,
    input  logic              short_pre,
    input  logic              tx_start,
    input  logic              tx_done,
    input  logic              ack,
    input  logic              amp_hot,
    input  logic              rssi_up,
    input  logic              rssi_dn,
    input  logic              gain_up,
    input  logic              gain_dn,
    output logic              hit
);
    logic [HIST_N-1:0]    rise, fall;
    logic [NUM_MODES-1:0] ev;
    logic [5:0]           tx_ev;

    assign rise = cur & ~prev;
    assign fall = ~cur & prev;

    // six transmit events shared by the plain and ACK-qualified groups
    assign tx_ev = {fall[H_RF], rise[H_RF], fall[H_BB], rise[H_BB], tx_done, tx_start};

    always_comb begin
        ev = '0;
        ev[int'(M_FCS_ANY)]   = fcs_done;
        ev[int'(M_FCS_OK)]    = fcs_done & fcs_ok;
        ev[int'(M_FCS_BAD)]   = fcs_done & ~fcs_ok;
        ev[int'(M_TXIQ_NZ)]   = rise[H_IQNZ];
        ev[int'(M_SIG_OK)]    = sig_done & sig_ok;
        ev[int'(M_SIG_BAD)]   = sig_done & ~sig_ok;
        ev[int'(M_SIG_HT)]    = sig_done & sig_ht;
        ev[int'(M_SIG_LEG)]   = sig_done & ~sig_ht;
        ev[int'(M_LONG_PRE)]  = long_pre;
        ev[int'(M_SHORT_PRE)] = short_pre;
        ev[int'(M_RSSI_UP)]   = rssi_up;
        ev[int'(M_RSSI_DN)]   = rssi_dn;
        ev[int'(M_UNLOCK)]    = fall[H_LOCK];
        ev[int'(M_LOCK)]      = rise[H_LOCK];
        ev[int'(M_GAIN_UP)]   = gain_up;
        ev[int'(M_GAIN_DN)]   = gain_dn;
        for (int k = 0; k < 6; k++) begin
            ev[int'(M_TX_START) + k]   = tx_ev[k];
            ev[int'(M_A_TX_START) + k] = tx_ev[k] & ack;
        end
        ev[int'(M_BB_AMP)]      = rise[H_BBA];
        ev[int'(M_RF_AMP)]      = rise[H_RFA];
        ev[int'(M_START_AMP)]   = tx_start & amp_hot;
        ev[int'(M_A_START_AMP)] = tx_start & amp_hot & ack;
    end

    assign hit = ev[mode];
endmodule

// File: rtl/capture_trigger_gen.sv
module capture_trigger_gen
    import trig_pkg::*;
#(
    parameter int IQ_W   = 16,
    parameter int RSSI_W = 11,
    parameter int GAIN_W = 7,
    parameter int AMP_W  = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [MODE_W-1:0]   mode_i,
    input  logic                free_run_i,
    input  logic                fcs_done_i,
    input  logic                fcs_ok_i,
    input  logic                sig_done_i,
    input  logic                sig_ok_i,
    input  logic                sig_ht_i,
    input  logic                long_pre_i,
    input  logic                short_pre_i,
    input  logic [2*IQ_W-1:0]   tx_iq_i,
    input  logic [RSSI_W-1:0]   rssi_i,
    input  logic [RSSI_W-1:0]   rssi_th_i,
    input  logic                gain_lock_i,
    input  logic [GAIN_W-1:0]   gain_i,
    input  logic [GAIN_W-1:0]   gain_th_i,
    input  logic                tx_start_i,
    input  logic                tx_done_i,
    input  logic                bb_on_i,
    input  logic                rf_on_i,
    input  logic                ack_req_i,
    input  logic [AMP_W-1:0]    amp_i,
    input  logic [AMP_W-1:0]    amp_th_i,
    output logic                trig_o
);
    trig_state_e       state_q, state_d;
    logic              amp_hot;
    logic [HIST_N-1:0] cur_v, prev_v;
    logic              rssi_up, rssi_dn, gain_up, gain_dn;
    logic              hit, fire;

    assign amp_hot = amp_i > amp_th_i;

    always_comb begin
        cur_v         = '0;
        cur_v[H_IQNZ] = |tx_iq_i;
        cur_v[H_LOCK] = gain_lock_i;
        cur_v[H_BB]   = bb_on_i;
        cur_v[H_RF]   = rf_on_i;
        cur_v[H_BBA]  = bb_on_i & amp_hot;
        cur_v[H_RFA]  = rf_on_i & amp_hot;
    end

    sig_history #(.N(HIST_N)) u_hist (
        .clk(clk), .rst_n(rst_n), .d(cur_v), .q(prev_v)
    );

    level_cross #(.W(RSSI_W)) u_rssi_x (
        .clk(clk), .rst_n(rst_n), .val(rssi_i), .th(rssi_th_i),
        .go_up(rssi_up), .go_dn(rssi_dn)
    );

    level_cross #(.W(GAIN_W)) u_gain_x (
        .clk(clk), .rst_n(rst_n), .val(gain_i), .th(gain_th_i),
        .go_up(gain_up), .go_dn(gain_dn)
    );

    event_mux u_mux (
        .mode(mode_i), .cur(cur_v), .prev(prev_v),
        .fcs_done(fcs_done_i), .fcs_ok(fcs_ok_i),
        .sig_done(sig_done_i), .sig_ok(sig_ok_i), .sig_ht(sig_ht_i),
        .long_pre(long_pre_i), .short_pre(short_pre_i),
        .tx_start(tx_start_i), .tx_done(tx_done_i), .ack(ack_req_i),
        .amp_hot(amp_hot),
        .rssi_up(rssi_up), .rssi_dn(rssi_dn),
        .gain_up(gain_up), .gain_dn(gain_dn),
        .hit(hit)
    );

    assign fire = (free_run_i && mode_i == M_FCS_ANY) || hit;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_PRIME;
        else        state_q <= state_d;
    end

    // next state: PRIME_TO_RUN after one clock, RUN holds
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_PRIME: state_d = ST_RUN;
            ST_RUN:   state_d = ST_RUN;
            default:  state_d = ST_PRIME;
        endcase
    end

    // output register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            trig_o <= 1'b0;
        end else begin
            unique case (state_q)
                ST_PRIME: trig_o <= 1'b0;
                ST_RUN:   trig_o <= fire;
                default:  trig_o <= 1'b0;
            endcase
        end
    end
endmodule

// File: rtl/trig_chk.sv
module trig_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [4:0] mode_i,
    input logic       free_run_i,
    input logic       fcs_done_i,
    input logic       fcs_ok_i,
    input logic       gain_lock_i,
    input logic       tx_start_i,
    input logic       ack_req_i,
    input logic       trig_o
);
    logic up_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) up_q <= 1'b0;
        else        up_q <= 1'b1;
    end

    // R1
    prime_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !up_q |=> !trig_o);

    // R3
    fcs_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (up_q && mode_i == 5'd1 && fcs_done_i && fcs_ok_i) |=> trig_o);

    // R3
    fcs_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == 5'd0 && !fcs_done_i && !free_run_i) |=> !trig_o);

    // R13
    free_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (up_q && mode_i == 5'd0 && free_run_i) |=> trig_o);

    // R8
    lock_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (up_q && mode_i == 5'd13 && $rose(gain_lock_i)) |=> trig_o);

    // R9
    tx_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (up_q && mode_i == 5'd16 && tx_start_i) |=> trig_o);

    // R10
    ack_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == 5'd22 && !ack_req_i) |=> !trig_o);
endmodule

bind capture_trigger_gen trig_chk u_chk (
    .clk(clk), .rst_n(rst_n), .mode_i(mode_i), .free_run_i(free_run_i),
    .fcs_done_i(fcs_done_i), .fcs_ok_i(fcs_ok_i), .gain_lock_i(gain_lock_i),
    .tx_start_i(tx_start_i), .ack_req_i(ack_req_i), .trig_o(trig_o)
);

// File: tb/sim_capture_trigger_gen.sv
`timescale 1ns/1ps
module sim_capture_trigger_gen;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  mode_i = '0;
    logic        free_run_i = 0, fcs_done_i = 0, fcs_ok_i = 0;
    logic        sig_done_i = 0, sig_ok_i = 0, sig_ht_i = 0;
    logic        long_pre_i = 0, short_pre_i = 0;
    logic [31:0] tx_iq_i = '0;
    logic [10:0] rssi_i = 11'd50, rssi_th_i = 11'd100;
    logic        gain_lock_i = 0;
    logic [6:0]  gain_i = 7'd10, gain_th_i = 7'd40;
    logic        tx_start_i = 0, tx_done_i = 0, bb_on_i = 0, rf_on_i = 0, ack_req_i = 0;
    logic [15:0] amp_i = '0, amp_th_i = 16'd1000;
    logic        trig_o;

    int n_chk = 0, n_fail = 0;
    bit done = 0;

    typedef struct { logic exp; string tag; } exp_t;
    exp_t sb[$];

    always #2.5 clk = ~clk;

    capture_trigger_gen u0 (
        .clk(clk), .rst_n(rst_n), .mode_i(mode_i), .free_run_i(free_run_i),
        .fcs_done_i(fcs_done_i), .fcs_ok_i(fcs_ok_i),
        .sig_done_i(sig_done_i), .sig_ok_i(sig_ok_i), .sig_ht_i(sig_ht_i),
        .long_pre_i(long_pre_i), .short_pre_i(short_pre_i), .tx_iq_i(tx_iq_i),
        .rssi_i(rssi_i), .rssi_th_i(rssi_th_i), .gain_lock_i(gain_lock_i),
        .gain_i(gain_i), .gain_th_i(gain_th_i), .tx_start_i(tx_start_i),
        .tx_done_i(tx_done_i), .bb_on_i(bb_on_i), .rf_on_i(rf_on_i),
        .ack_req_i(ack_req_i), .amp_i(amp_i), .amp_th_i(amp_th_i), .trig_o(trig_o)
    );

    // driver: inputs are already set at a falling edge; queue the result due at the next rising edge
    task automatic tick(input logic exp, input string tag);
        exp_t e;
        e.exp = exp;
        e.tag = tag;
        sb.push_back(e);
        @(negedge clk);
    endtask

    // monitor
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (sb.size() > 0) begin
                exp_t e;
                e = sb.pop_front();
                n_chk++;
                if (trig_o !== e.exp) begin
                    n_fail++;
                    $display("FAIL %s: trig_o=%0b expected %0b", e.tag, trig_o, e.exp);
                end
            end
        end
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        n_chk++;
        if (trig_o !== 1'b0) begin
            n_fail++;
            $display("FAIL R1 reset: trig_o=%0b expected 0", trig_o);
        end
        rst_n = 1'b1;

        // R1 prime cycle then R13 free run
        mode_i = 5'd0; free_run_i = 1;
        tick(0, "R1 first clock after reset");
        tick(1, "R13 free run");
        tick(1, "R13 free run");
        mode_i = 5'd1;
        tick(0, "R13 free run ignored in mode 1");
        free_run_i = 0;

        // R3 frame check modes
        mode_i = 5'd0; fcs_done_i = 1; fcs_ok_i = 0;
        tick(1, "R3 mode 0 any result");
        fcs_done_i = 0;
        tick(0, "R2 pulse ends");
        mode_i = 5'd1; fcs_done_i = 1; fcs_ok_i = 1;
        tick(1, "R3 mode 1 pass");
        fcs_ok_i = 0;
        tick(0, "R3 mode 1 fail ignored");
        mode_i = 5'd2;
        tick(1, "R3 mode 2 fail");
        fcs_ok_i = 1;
        tick(0, "R3 mode 2 pass ignored");
        fcs_done_i = 0; fcs_ok_i = 0;

        // R4 header check modes
        mode_i = 5'd4; sig_done_i = 1; sig_ok_i = 1;
        tick(1, "R4 mode 4 pass");
        sig_ok_i = 0;
        tick(0, "R4 mode 4 fail ignored");
        mode_i = 5'd5;
        tick(1, "R4 mode 5 fail");
        mode_i = 5'd6; sig_ht_i = 1;
        tick(1, "R4 mode 6 HT");
        sig_ht_i = 0;
        tick(0, "R4 mode 6 non-HT ignored");
        mode_i = 5'd7;
        tick(1, "R4 mode 7 non-HT");
        sig_ht_i = 1;
        tick(0, "R4 mode 7 HT ignored");
        sig_done_i = 0; sig_ht_i = 0;

        // R5 preambles and first nonzero transmit word
        mode_i = 5'd8; long_pre_i = 1;
        tick(1, "R5 mode 8 long");
        long_pre_i = 0; short_pre_i = 1;
        tick(0, "R5 mode 8 short ignored");
        mode_i = 5'd9;
        tick(1, "R5 mode 9 short");
        short_pre_i = 0;
        tick(0, "R5 mode 9 idle");
        mode_i = 5'd3; tx_iq_i = 32'h0001_0000;
        tick(1, "R5 mode 3 zero to nonzero");
        tx_iq_i = 32'h0000_0005;
        tick(0, "R5 mode 3 stays nonzero");
        tx_iq_i = '0;
        tick(0, "R5 mode 3 back to zero");
        tx_iq_i = 32'h0000_0001;
        tick(1, "R5 mode 3 nonzero again");
        tx_iq_i = '0;
        tick(0, "R5 mode 3 zero");

        // R6 RSSI crossings, threshold 100
        mode_i = 5'd10; rssi_i = 11'd150;
        tick(1, "R6 rssi crosses above");
        rssi_i = 11'd200;
        tick(0, "R6 rssi stays above");
        rssi_i = 11'd100;
        tick(0, "R6 rssi equal no event");
        mode_i = 5'd11; rssi_i = 11'd99;
        tick(1, "R6 rssi crosses below");
        rssi_i = 11'd20;
        tick(0, "R6 rssi stays below");
        mode_i = 5'd10; rssi_i = 11'd101;
        tick(1, "R6 rssi above again");

        // R7 gain crossings, threshold 40
        mode_i = 5'd14; gain_i = 7'd41;
        tick(1, "R7 gain crosses above");
        gain_i = 7'd60;
        tick(0, "R7 gain stays above");
        mode_i = 5'd15; gain_i = 7'd39;
        tick(1, "R7 gain crosses below");
        gain_i = 7'd0;
        tick(0, "R7 gain stays below");

        // R8 lock transitions
        mode_i = 5'd13; gain_lock_i = 1;
        tick(1, "R8 unlock to lock");
        tick(0, "R8 lock held");
        mode_i = 5'd12; gain_lock_i = 0;
        tick(1, "R8 lock to unlock");
        tick(0, "R8 unlock held");

        // R9 transmit events
        mode_i = 5'd16; tx_start_i = 1;
        tick(1, "R9 mode 16 start");
        tx_start_i = 0;
        tick(0, "R9 mode 16 idle");
        mode_i = 5'd17; tx_done_i = 1;
        tick(1, "R9 mode 17 done");
        tx_done_i = 0;
        mode_i = 5'd18; bb_on_i = 1;
        tick(1, "R9 mode 18 bb rise");
        tick(0, "R9 mode 18 bb held");
        mode_i = 5'd19; bb_on_i = 0;
        tick(1, "R9 mode 19 bb fall");
        mode_i = 5'd20; rf_on_i = 1;
        tick(1, "R9 mode 20 rf rise");
        mode_i = 5'd21; rf_on_i = 0;
        tick(1, "R9 mode 21 rf fall");
        tick(0, "R9 mode 21 idle");

        // R10 ACK-qualified transmit events
        mode_i = 5'd22; ack_req_i = 0; tx_start_i = 1;
        tick(0, "R10 mode 22 no ack");
        ack_req_i = 1;
        tick(1, "R10 mode 22 with ack");
        tx_start_i = 0;
        mode_i = 5'd23; tx_done_i = 1;
        tick(1, "R10 mode 23 with ack");
        ack_req_i = 0;
        tick(0, "R10 mode 23 no ack");
        tx_done_i = 0;
        mode_i = 5'd24; ack_req_i = 1; bb_on_i = 1;
        tick(1, "R10 mode 24 bb rise ack");
        mode_i = 5'd25; ack_req_i = 0; bb_on_i = 0;
        tick(0, "R10 mode 25 bb fall no ack");
        mode_i = 5'd26; ack_req_i = 1; rf_on_i = 1;
        tick(1, "R10 mode 26 rf rise ack");
        mode_i = 5'd27; rf_on_i = 0;
        tick(1, "R10 mode 27 rf fall ack");
        ack_req_i = 0;

        // R11 ongoing with other-antenna amplitude, threshold 1000
        mode_i = 5'd28; amp_i = 16'd2000;
        tick(0, "R11 amplitude without bb");
        bb_on_i = 1;
        tick(1, "R11 bb and amplitude");
        tick(0, "R11 held no repeat");
        amp_i = 16'd0;
        tick(0, "R11 amplitude drops");
        amp_i = 16'd2000;
        tick(1, "R11 amplitude returns");
        mode_i = 5'd29; rf_on_i = 1;
        tick(1, "R11 rf and amplitude");
        rf_on_i = 0; bb_on_i = 0;
        tick(0, "R11 rf off");

        // R12 transmit start with amplitude
        mode_i = 5'd30; tx_start_i = 1;
        tick(1, "R12 mode 30 start with amplitude");
        amp_i = 16'd1000;
        tick(0, "R12 mode 30 amplitude at threshold");
        mode_i = 5'd31; amp_i = 16'd2000; ack_req_i = 0;
        tick(0, "R12 mode 31 no ack");
        ack_req_i = 1;
        tick(1, "R12 mode 31 with ack");
        tx_start_i = 0; ack_req_i = 0; amp_i = '0;
        tick(0, "R12 idle");

        repeat (2) @(negedge clk);
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule